// File: doc/BRIEF.md
# ADC Single-Shot Conversion Sequencer

This block sits on the host side of an external converter that has a 16-bit register interface and is reached over I2C. Its other side is a register-level request port to an I2C master, which lies outside the block. One pulse on `start` runs one complete conversion. The sequence has four steps:

1. A read-modify-write of the control register sets the start-conversion bit.
2. The block waits a settling time chosen by the data-rate code it just read.
3. It polls the ready bit at a fixed interval until the bit is set.
4. It fetches the data register.

The raw 16-bit two's-complement code is reduced to the selected resolution by a signed division that truncates toward zero. It is returned on `sample` together with a one-cycle `done`.

Every wait is counted in microseconds. A prescaler turns `US_CYCLES` clock cycles into one microsecond, and it restarts whenever a wait is loaded, so each wait lasts an exact number of cycles. An error flagged by the master on any transfer ends the sequence at once. The block then pulses `error` in place of `done`.

Top module: `adc_oneshot_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `bus_req` are 0 and `sample` is 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle. In that same cycle a read request (`bus_wr`=0) to pointer 0x01 (control register) is presented.
- R3: `start` pulses while `busy` is high are ignored: they cause no extra bus transfer and no second completion.
- R4: When the control read is acknowledged, the block writes pointer 0x01 with the value it read, with bit 15 forced to 1 and all other bits unchanged.
- R5: With RES_BITS=16, the rate code is bits 7:5 of the control value read. The first ready poll is requested (D+25)*US_CYCLES cycles after the cycle that follows the write's acknowledge. D is 125000, 62500, 31250, 15625, 7813, 4000, 2105 or 1163 for codes 0 to 7.
- R6: With RES_BITS=12, the same timing holds with D equal to 7813, 4000, 2041, 1087, 625, 417, 303 or 303 for codes 0 to 7.
- R7: A poll is a read of pointer 0x01. If bit 15 of the returned value is 0, the next poll is requested 100*US_CYCLES cycles after the cycle that follows that acknowledge.
- R8: A poll that returns bit 15 = 1 leads to a read of pointer 0x00. Its acknowledge pulses `done` for exactly one cycle and updates `sample` on the same edge, and `busy` is low from that cycle on.
- R9: `sample` equals the data read as signed 16-bit, divided by 2^(16-RES_BITS) with truncation toward zero, as a RES_BITS-wide two's-complement value. For example, with 12 bits, 0xFFE8 gives -1 and 0xFFFF gives 0.
- R10: An acknowledge with `bus_err`=1 on any transfer ends the sequence. `error` pulses for one cycle, `done` stays low, `busy` falls, no further request is made, and `sample` keeps its old value.
- R11: Once raised, `bus_req` stays high with `bus_ptr`, `bus_wr` and `bus_wdata` unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one conversion (ignored while busy) |
| bus_req | output | 1 | Register transfer request to the I2C master |
| bus_wr | output | 1 | 1 = register write, 0 = register read |
| bus_ptr | output | 8 | Register pointer of the transfer |
| bus_wdata | output | 16 | Value to write |
| bus_ack | input | 1 | One-cycle completion of the pending transfer |
| bus_err | input | 1 | Qualifies `bus_ack` as a failed transfer |
| bus_rdata | input | 16 | Read value, valid with `bus_ack` |
| busy | output | 1 | A conversion sequence is in progress |
| done | output | 1 | One-cycle pulse: `sample` holds a new result |
| error | output | 1 | One-cycle pulse: sequence aborted by a bus error |
| sample | output | RES_BITS | Scaled signed conversion result |

## Verification
The assertions assume that the master raises `bus_ack` for a single cycle, and only while a request is pending. They also assume that `bus_err` matters only together with `bus_ack`, and that every loaded wait is at least one microsecond long. The bench's bus stub follows this contract: it answers each request after a fixed latency with a one-cycle acknowledge. It returns ready or not-ready control values on a per-run schedule and raises the error flag on exactly one chosen transfer. The stub also times each request and counts any change to the request fields while a transfer is pending.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CFG_RD,
        S_CFG_WR,
        S_SETTLE,
        S_POLL_RD,
        S_POLL_GAP,
        S_DATA_RD
    } seq_state_e;

    // register pointers decoded by the converter
    localparam logic [7:0] PTR_DATA = 8'h00;
    localparam logic [7:0] PTR_CTRL = 8'h01;

    // control register fields the sequence depends on
    localparam int GO_BIT   = 15;
    localparam int RATE_LSB = 5;
    localparam int RATE_W   = 3;

    localparam int REG_W = 16;
    localparam int DLY_W = 17;

endpackage

// File: rtl/adc_rate_delay.sv
module adc_rate_delay #(
    parameter int RES_BITS = 16,
    parameter int DLY_W    = 17
) (
    input  logic [2:0]       code,
    output logic [DLY_W-1:0] delay_us
);

    generate
        if (RES_BITS == 16) begin : g_wide
            always_comb begin
                case (code)
                    3'd0:    delay_us = DLY_W'(125000);
                    3'd1:    delay_us = DLY_W'(62500);
                    3'd2:    delay_us = DLY_W'(31250);
                    3'd3:    delay_us = DLY_W'(15625);
                    3'd4:    delay_us = DLY_W'(7813);
                    3'd5:    delay_us = DLY_W'(4000);
                    3'd6:    delay_us = DLY_W'(2105);
                    default: delay_us = DLY_W'(1163);
                endcase
            end
        end else begin : g_narrow
            always_comb begin
                case (code)
                    3'd0:    delay_us = DLY_W'(7813);
                    3'd1:    delay_us = DLY_W'(4000);
                    3'd2:    delay_us = DLY_W'(2041);
                    3'd3:    delay_us = DLY_W'(1087);
                    3'd4:    delay_us = DLY_W'(625);
                    3'd5:    delay_us = DLY_W'(417);
                    default: delay_us = DLY_W'(303);
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/adc_us_timer.sv
module adc_us_timer #(
    parameter int US_CYCLES = 200,
    parameter int CNT_W     = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_us,
    output logic             expire
);

    localparam int PRE_W = (US_CYCLES > 1) ? $clog2(US_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(US_CYCLES - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] rem;
        logic             run;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic us_tick;

    assign us_tick = tmr_q.run && (tmr_q.pre == PRE_LAST);
    assign expire  = us_tick && (tmr_q.rem == CNT_W'(1));

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.pre = '0;
            tmr_d.rem = load_us;
            tmr_d.run = 1'b1;
        end else if (tmr_q.run) begin
            if (us_tick) begin
                tmr_d.pre = '0;
                tmr_d.rem = tmr_q.rem - CNT_W'(1);
                if (tmr_q.rem == CNT_W'(1)) begin
                    tmr_d.run = 1'b0;
                end
            end else begin
                tmr_d.pre = tmr_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R5
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_us != '0));

    // R7
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && !load && !us_tick) |=> (tmr_q.rem == $past(tmr_q.rem)));

endmodule

// File: rtl/adc_sample_scale.sv
module adc_sample_scale #(
    parameter int RES_BITS = 16
) (
    input  logic [15:0]         raw,
    output logic [RES_BITS-1:0] scaled
);

    localparam int SHIFT = 16 - RES_BITS;

    generate
        if (SHIFT == 0) begin : g_pass
            assign scaled = raw[RES_BITS-1:0];
        end else begin : g_div
            localparam logic [16:0] BIAS = (17'd1 << SHIFT) - 17'd1;
            logic [16:0] biased;
            always_comb begin
                // negative codes get 2^SHIFT-1 added so the shift rounds toward zero
                biased = {raw[15], raw} + (raw[15] ? BIAS : 17'd0);
                scaled = biased[SHIFT +: RES_BITS];
            end
        end
    endgenerate

endmodule

// File: rtl/adc_oneshot_seq.sv
module adc_oneshot_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS  = 16,
    parameter int US_CYCLES = 200,
    parameter int WAKE_US   = 25,
    parameter int POLL_US   = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                bus_req,
    output logic                bus_wr,
    output logic [7:0]          bus_ptr,
    output logic [REG_W-1:0]    bus_wdata,
    input  logic                bus_ack,
    input  logic                bus_err,
    input  logic [REG_W-1:0]    bus_rdata,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic [RES_BITS-1:0] sample
);

    typedef struct packed {
        seq_state_e          st;
        logic [REG_W-1:0]    wval;
        logic [RES_BITS-1:0] smp;
        logic                done;
        logic                err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             tmr_load;
    logic [DLY_W-1:0] tmr_val;
    logic             tmr_exp;
    logic [DLY_W-1:0] rate_dly;
    logic [RES_BITS-1:0] scaled;
    logic             xfer_ok;
    logic             xfer_bad;

    adc_rate_delay #(
        .RES_BITS (RES_BITS),
        .DLY_W    (DLY_W)
    ) u_rate_delay (
        .code     (seq_q.wval[RATE_LSB +: RATE_W]),
        .delay_us (rate_dly)
    );

    adc_us_timer #(
        .US_CYCLES (US_CYCLES),
        .CNT_W     (DLY_W)
    ) u_us_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_us (tmr_val),
        .expire  (tmr_exp)
    );

    adc_sample_scale #(
        .RES_BITS (RES_BITS)
    ) u_sample_scale (
        .raw    (bus_rdata),
        .scaled (scaled)
    );

    assign xfer_ok  = bus_ack && !bus_err;
    assign xfer_bad = bus_ack && bus_err;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        case (seq_q.st)
            S_IDLE: begin
                if (start) begin
                    seq_d.st = S_CFG_RD;
                end
            end
            S_CFG_RD: begin
                if (xfer_bad) begin
                    seq_d.err = 1'b1;
                    seq_d.st  = S_IDLE;
                end else if (xfer_ok) begin
                    seq_d.wval         = bus_rdata;
                    seq_d.wval[GO_BIT] = 1'b1;
                    seq_d.st           = S_CFG_WR;
                end
            end
            S_CFG_WR: begin
                if (xfer_bad) begin
                    seq_d.err = 1'b1;
                    seq_d.st  = S_IDLE;
                end else if (xfer_ok) begin
                    tmr_load = 1'b1;
                    tmr_val  = rate_dly + DLY_W'(WAKE_US);
                    seq_d.st = S_SETTLE;
                end
            end
            S_SETTLE, S_POLL_GAP: begin
                if (tmr_exp) begin
                    seq_d.st = S_POLL_RD;
                end
            end
            S_POLL_RD: begin
                if (xfer_bad) begin
                    seq_d.err = 1'b1;
                    seq_d.st  = S_IDLE;
                end else if (xfer_ok) begin
                    if (bus_rdata[GO_BIT]) begin
                        seq_d.st = S_DATA_RD;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = DLY_W'(POLL_US);
                        seq_d.st = S_POLL_GAP;
                    end
                end
            end
            S_DATA_RD: begin
                if (xfer_bad) begin
                    seq_d.err = 1'b1;
                    seq_d.st  = S_IDLE;
                end else if (xfer_ok) begin
                    seq_d.smp  = scaled;
                    seq_d.done = 1'b1;
                    seq_d.st   = S_IDLE;
                end
            end
            default: begin
                seq_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, wval: '0, smp: '0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_req   = (seq_q.st == S_CFG_RD) || (seq_q.st == S_CFG_WR) ||
                       (seq_q.st == S_POLL_RD) || (seq_q.st == S_DATA_RD);
    assign bus_wr    = (seq_q.st == S_CFG_WR);
    assign bus_ptr   = (seq_q.st == S_DATA_RD) ? PTR_DATA : PTR_CTRL;
    assign bus_wdata = seq_q.wval;
    assign busy      = (seq_q.st != S_IDLE);
    assign done      = seq_q.done;
    assign error     = seq_q.err;
    assign sample    = seq_q.smp;

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_ptr) && $stable(bus_wr) && $stable(bus_wdata)));

    // R4
    go_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr) |-> (bus_wdata[GO_BIT] && bus_ptr == PTR_CTRL));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && !error));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!busy && !bus_req && $past(bus_ack && bus_err)));

    // R7
    wake_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_exp |-> ((seq_q.st == S_SETTLE) || (seq_q.st == S_POLL_GAP)));

    // R9
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((sample[RES_BITS-1] == $past(bus_rdata[15])) || (sample == '0)));

endmodule

// File: tb/adc_oneshot_seq_bench.sv
`timescale 1ns/1ps

module adc_bus_stub #(
    parameter int LAT = 3
) (
    input  logic        clk,
    input  logic        clr,
    input  logic [15:0] cfg_base,
    input  int          not_ready,
    input  logic [15:0] conv_val,
    input  int          err_txn,
    input  logic        req,
    input  logic        wr,
    input  logic [7:0]  ptr,
    input  logic [15:0] wdata,
    output logic        ack,
    output logic        err,
    output logic [15:0] rdata,
    output int          n_txn,
    output int          n_rd_cfg,
    output int          n_wr_cfg,
    output int          n_rd_conv,
    output int          n_unstable,
    output logic [15:0] wr_seen,
    output int          t_wr,
    output int          t_poll1,
    output int          t_poll2
);
    int cyc = 0;
    int polls;
    logic [7:0]  h_ptr;
    logic        h_wr;
    logic [15:0] h_data;
    logic [15:0] resp;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic zero_stats();
        n_txn = 0; n_rd_cfg = 0; n_wr_cfg = 0; n_rd_conv = 0; n_unstable = 0;
        wr_seen = 0; t_wr = 0; t_poll1 = 0; t_poll2 = 0; polls = 0;
    endtask

    initial begin
        ack = 0; err = 0; rdata = 0;
        zero_stats();
        @(negedge clk);
        forever begin
            if (clr) begin
                zero_stats();
                @(negedge clk);
            end else if (req) begin
                h_ptr = ptr; h_wr = wr; h_data = wdata;
                n_txn++;
                resp = 16'h0000;
                if (h_wr) begin
                    n_wr_cfg++; wr_seen = h_data; t_wr = cyc;
                end else if (h_ptr == 8'h01) begin
                    n_rd_cfg++;
                    if (n_wr_cfg == 0) begin
                        resp = cfg_base;
                    end else begin
                        polls++;
                        if (polls == 1) t_poll1 = cyc;
                        if (polls == 2) t_poll2 = cyc;
                        resp = (polls <= not_ready) ? (cfg_base & 16'h7FFF) : (cfg_base | 16'h8000);
                    end
                end else if (h_ptr == 8'h00) begin
                    n_rd_conv++;
                    resp = conv_val;
                end
                for (int i = 0; i < LAT; i++) begin
                    @(negedge clk);
                    if (!req || ptr != h_ptr || wr != h_wr || wdata != h_data) n_unstable++;
                end
                ack = 1; err = (n_txn == err_txn); rdata = resp;
                @(negedge clk);
                ack = 0; err = 0;
            end else begin
                @(negedge clk);
            end
        end
    end
endmodule

module adc_oneshot_seq_bench;
    localparam int U   = 2;
    localparam int LAT = 3;

    typedef struct packed {
        logic [15:0] cfg;
        logic [7:0]  nr;
        logic [15:0] conv;
        logic [15:0] exp;
    } vec_t;

    // 12-bit instance: rate code is cfg[7:5]
    localparam vec_t VECS [6] = '{
        '{16'h0583, 8'd0, 16'h7FF0, 16'h07FF},
        '{16'h45E3, 8'd2, 16'h8000, 16'hF800},
        '{16'h32A0, 8'd1, 16'hFFFF, 16'h0000},
        '{16'h0000, 8'd0, 16'hFFE8, 16'hFFFF},
        '{16'h7C7F, 8'd3, 16'h0017, 16'h0001},
        '{16'h8123, 8'd0, 16'hFFF0, 16'hFFFF}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic start_tb = 0;
    logic cur = 0;
    logic m_clr = 0;
    logic [15:0] m_cfg = 0, m_conv = 0;
    int m_nr = 0, m_et = 0;

    always #2.5 clk = ~clk;

    logic req0, wr0, ack0, err0, busy0, done0, error0;
    logic [7:0] ptr0;
    logic [15:0] wd0, rd0;
    logic [11:0] smp0;
    logic req1, wr1, ack1, err1, busy1, done1, error1;
    logic [7:0] ptr1;
    logic [15:0] wd1, rd1, smp1;
    int nt0, nrc0, nwc0, ncv0, nun0, tw0, tp10, tp20;
    int nt1, nrc1, nwc1, ncv1, nun1, tw1, tp11, tp21;
    logic [15:0] ws0, ws1;

    adc_oneshot_seq #(.RES_BITS(12), .US_CYCLES(U)) u_adc_oneshot_seq (
        .clk(clk), .rst_n(rst_n), .start(start_tb && !cur),
        .bus_req(req0), .bus_wr(wr0), .bus_ptr(ptr0), .bus_wdata(wd0),
        .bus_ack(ack0), .bus_err(err0), .bus_rdata(rd0),
        .busy(busy0), .done(done0), .error(error0), .sample(smp0));

    adc_oneshot_seq #(.RES_BITS(16), .US_CYCLES(U)) u_adc_oneshot_seq_w16 (
        .clk(clk), .rst_n(rst_n), .start(start_tb && cur),
        .bus_req(req1), .bus_wr(wr1), .bus_ptr(ptr1), .bus_wdata(wd1),
        .bus_ack(ack1), .bus_err(err1), .bus_rdata(rd1),
        .busy(busy1), .done(done1), .error(error1), .sample(smp1));

    adc_bus_stub #(.LAT(LAT)) u_stub0 (
        .clk(clk), .clr(m_clr), .cfg_base(m_cfg), .not_ready(m_nr), .conv_val(m_conv), .err_txn(m_et),
        .req(req0), .wr(wr0), .ptr(ptr0), .wdata(wd0), .ack(ack0), .err(err0), .rdata(rd0),
        .n_txn(nt0), .n_rd_cfg(nrc0), .n_wr_cfg(nwc0), .n_rd_conv(ncv0), .n_unstable(nun0),
        .wr_seen(ws0), .t_wr(tw0), .t_poll1(tp10), .t_poll2(tp20));

    adc_bus_stub #(.LAT(LAT)) u_stub1 (
        .clk(clk), .clr(m_clr), .cfg_base(m_cfg), .not_ready(m_nr), .conv_val(m_conv), .err_txn(m_et),
        .req(req1), .wr(wr1), .ptr(ptr1), .wdata(wd1), .ack(ack1), .err(err1), .rdata(rd1),
        .n_txn(nt1), .n_rd_cfg(nrc1), .n_wr_cfg(nwc1), .n_rd_conv(ncv1), .n_unstable(nun1),
        .wr_seen(ws1), .t_wr(tw1), .t_poll1(tp11), .t_poll2(tp21));

    // views of the selected instance
    logic v_busy, v_done, v_err, v_req;
    logic [7:0] v_ptr;
    logic [15:0] v_smp, v_ws;
    int v_nt, v_nrc, v_nwc, v_ncv, v_nun, v_tw, v_tp1, v_tp2;
    always_comb begin
        v_busy = cur ? busy1 : busy0;
        v_done = cur ? done1 : done0;
        v_err  = cur ? error1 : error0;
        v_req  = cur ? req1 : req0;
        v_ptr  = cur ? ptr1 : ptr0;
        v_smp  = cur ? smp1 : {{4{smp0[11]}}, smp0};
        v_ws   = cur ? ws1 : ws0;
        v_nt   = cur ? nt1 : nt0;
        v_nrc  = cur ? nrc1 : nrc0;
        v_nwc  = cur ? nwc1 : nwc0;
        v_ncv  = cur ? ncv1 : ncv0;
        v_nun  = cur ? nun1 : nun0;
        v_tw   = cur ? tw1 : tw0;
        v_tp1  = cur ? tp11 : tp10;
        v_tp2  = cur ? tp21 : tp20;
    end

    int checks = 0;
    int failures = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int dly16(input int code);
        case (code)
            0: return 125000; 1: return 62500; 2: return 31250; 3: return 15625;
            4: return 7813;   5: return 4000;  6: return 2105;  default: return 1163;
        endcase
    endfunction

    function automatic int dly12(input int code);
        case (code)
            0: return 7813; 1: return 4000; 2: return 2041; 3: return 1087;
            4: return 625;  5: return 417;  default: return 303;
        endcase
    endfunction

    logic r_busy0, r_req0, r_done, r_err, r_busy_end, r_pulse_ok, r_quiet;
    logic [7:0] r_ptr0;
    logic [15:0] r_smp;

    task automatic run_conv(input logic [15:0] cfg, input int nr, input logic [15:0] conv,
                            input int et, input bit dbl);
        int n;
        int snap;
        @(posedge clk); #1;
        m_cfg = cfg; m_nr = nr; m_conv = conv; m_et = et; m_clr = 1;
        @(posedge clk); #1; m_clr = 0;
        @(posedge clk); #1; start_tb = 1;
        @(posedge clk); #1; start_tb = 0;
        @(negedge clk);
        r_busy0 = v_busy; r_req0 = v_req; r_ptr0 = v_ptr;
        if (dbl) begin
            repeat (4) @(posedge clk);
            #1; start_tb = 1;
            @(posedge clk); #1; start_tb = 0;
        end
        n = 0;
        while (!(v_done || v_err) && n < 60000) begin
            @(negedge clk);
            n++;
        end
        r_done = v_done; r_err = v_err; r_busy_end = v_busy; r_smp = v_smp;
        @(negedge clk);
        r_pulse_ok = !v_done && !v_err;
        snap = v_nt;
        repeat (10) @(negedge clk);
        r_quiet = (v_nt == snap) && !v_req && !v_busy;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] prev;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", busy0, 0);
        chk("R1 done/error", {done0, error0}, 0);
        chk("R1 bus_req", req0, 0);
        chk("R1 sample", smp0, 0);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 idle after release", {busy0, req0, busy1, req1}, 0);

        // table walk on the 12-bit instance
        cur = 0;
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            int rate;
            v = VECS[i];
            rate = int'(v.cfg[7:5]);
            run_conv(v.cfg, int'(v.nr), v.conv, 0, 0);
            chk("R2 busy after start", r_busy0, 1);
            chk("R2 first request ctrl read", {r_req0, r_ptr0}, {1'b1, 8'h01});
            chk("R4 written value", v_ws, v.cfg | 16'h8000);
            chk("R6 settle gap", v_tp1 - v_tw, LAT + 1 + (dly12(rate) + 25) * U);
            if (v.nr > 0) chk("R7 poll gap", v_tp2 - v_tp1, LAT + 1 + 100 * U);
            chk("R7 ctrl reads", v_nrc, int'(v.nr) + 2);
            chk("R8 done pulse", {r_done, r_err, r_busy_end, r_pulse_ok}, 4'b1001);
            chk("R8 one data read", v_ncv, 1);
            chk("R9 scaled sample", r_smp, v.exp);
            chk("R11 request stable", v_nun, 0);
        end

        // 16-bit instance
        cur = 1;
        run_conv(16'h00E0, 1, 16'h8001, 0, 0);
        chk("R5 settle gap code7", v_tp1 - v_tw, LAT + 1 + (dly16(7) + 25) * U);
        chk("R7 poll gap w16", v_tp2 - v_tp1, LAT + 1 + 100 * U);
        chk("R9 full width sample", r_smp, 16'h8001);
        run_conv(16'h00C5, 0, 16'h1234, 0, 0);
        chk("R5 settle gap code6", v_tp1 - v_tw, LAT + 1 + (dly16(6) + 25) * U);
        chk("R8 done w16", {r_done, r_err}, 2'b10);
        chk("R9 full width sample 2", r_smp, 16'h1234);
        chk("R11 request stable w16", v_nun, 0);

        // start while busy
        cur = 0;
        run_conv(16'h00E3, 0, 16'h0100, 0, 1);
        chk("R3 ctrl reads", v_nrc, 2);
        chk("R3 ctrl writes", v_nwc, 1);
        chk("R3 single completion", {r_done, r_pulse_ok, r_quiet}, 3'b111);
        chk("R9 positive sample", r_smp, 16'h0010);

        // bus errors at each step
        prev = r_smp;
        run_conv(16'h00E3, 0, 16'h0400, 1, 0);
        chk("R10 abort on ctrl read", {r_err, r_done, r_busy_end, r_pulse_ok, r_quiet}, 5'b10011);
        chk("R10 no write after abort", v_nwc, 0);
        chk("R10 sample kept", r_smp, prev);
        run_conv(16'h00E3, 0, 16'h0400, 2, 0);
        chk("R10 abort on write", {r_err, r_done, r_quiet}, 3'b101);
        chk("R10 no poll after write error", v_nrc, 1);
        run_conv(16'h00E3, 0, 16'h0400, 3, 0);
        chk("R10 abort on poll", {r_err, r_done, r_quiet}, 3'b101);
        chk("R10 no data read after poll error", v_ncv, 0);
        run_conv(16'h00E3, 0, 16'h0400, 4, 0);
        chk("R10 abort on data read", {r_err, r_done, r_quiet}, 3'b101);
        chk("R10 sample kept after data error", r_smp, prev);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule